// File: doc/BRIEF.md
# UART Receiver with Mute and Idle-Line Wake-Up

This block is an asynchronous serial receiver. It uses an external oversampling tick (16 ticks per bit) to sample one serial input line. It finds start bits and checks each start bit at its midpoint. It samples eight data bits, least significant first, and checks the stop bit. A good character goes into a receive data register and raises a data-ready flag. If a character arrives while data-ready is still set, the new character is dropped and an overrun flag is raised. After a character, a full frame time of continuous high level on the line raises an idle flag.

Software writes one 8-bit control word. It holds the receive enable, two interrupt enables and a mute bit. While mute is set, arriving characters change neither the data register nor any flag. Hardware clears mute when it sees an idle line. The receiver can only wake this way if at least one character was received before mute was entered. A single acknowledge strobe clears the three flags. Two interrupt outputs gate the flags with their enables.

Top module: `mute_uart_rx`

## Requirements
- R1: The control word uses bit 5 = receive interrupt enable, bit 4 = idle interrupt enable, bit 2 = receive enable and bit 1 = mute. All four reset to 0. `ctlQ` reads back those four bits in the same positions, with every other bit 0.
- R2: While the receive enable is 0, the receiver ignores the line. A complete frame then sets no flag and leaves the data register unchanged.
- R3: With receive enable 1, a low level on the line starts a frame. Each bit is sampled at its midpoint at 16 ticks per bit, least significant bit first. A good frame loads the byte into `rxData` and sets `dataReady`.
- R4: `rxIrq` is 1 exactly when bit 5 is 1 and `dataReady` or `overrun` is 1.
- R5: If a good frame completes while `dataReady` is 1, `overrun` is set and `rxData` keeps the earlier byte.
- R6: After a received character, 160 consecutive ticks of high line (one 10-bit frame time) set `idleFlag`. `idleIrq` is 1 exactly when bit 4 is 1 and `idleFlag` is 1.
- R7: `idleFlag` is set only once per character: after it is cleared, further idle time does not set it again. A pulse on `ackRd` clears `dataReady`, `overrun` and `idleFlag`.
- R8: A start bit that is no longer low at its midpoint (8 ticks after detection) is dropped as noise, and no character results.
- R9: A frame whose stop bit is sampled low is discarded without setting any flag.
- R10: While mute is 1, completed frames do not change `rxData`, `dataReady` or `overrun`.
- R11: While mute is 1, an idle line after a character clears mute and sets `idleFlag`. This works only if a character was received while not muted at some earlier time.
- R12: If mute is set before any character has ever been received, frames that arrive do not arm idle detection. Mute then stays set until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling tick, 16 per bit time, one clock wide |
| rxIn | input | 1 | Serial input line, high when idle |
| ctlWe | input | 1 | Write strobe for the control word |
| ctlWdata | input | 8 | Control word write data |
| ackRd | input | 1 | Clears data-ready, overrun and idle flags |
| ctlQ | output | 8 | Control word readback |
| rxData | output | 8 | Receive data register |
| dataReady | output | 1 | Character available |
| overrun | output | 1 | A character was lost because data-ready was set |
| idleFlag | output | 1 | Idle line seen after a character |
| rxIrq | output | 1 | Receive interrupt request |
| idleIrq | output | 1 | Idle-line interrupt request |

## Verification
The bench attacks the one-shot nature of idle detection. A design that re-arms on any high line would raise the idle flag again after an acknowledge. A design that arms at reset would wake from mute with no prior character. The bench also sends a glitch shorter than half a bit, and a frame with a low stop bit. A receiver that skips the midpoint check or the stop check would deliver a bogus byte in these cases. In the overrun case, a design that overwrites the register would show the second byte instead of the first. Muted frames must leave the data and flags untouched, and the idle wake must clear the mute bit as seen on readback.

// File: rtl/mute_uart_rx_pkg.sv
package mute_uart_rx_pkg;
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rxState_t;

  typedef struct packed {
    logic shiftEn;    // sample a data bit
    logic bitVal;     // sampled value
    logic frameOk;    // stop bit sampled high
    logic quietTick;  // tick with line high while waiting
    logic quietBreak; // line activity or receiver off
  } rxStrobe_t;
endpackage

// File: rtl/mute_uart_rx_ctrl.sv
module mute_uart_rx_ctrl
  import mute_uart_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxIn,
  input  logic       rxEn,
  output rxStrobe_t  strb
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_BITS);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

  logic [1:0]       syncQ;
  logic             rxS;
  rxState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitIdx;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxIn};
  end
  assign rxS = syncQ[1];

  always_comb begin
    strb            = '0;
    strb.quietTick  = tick && rxS && rxEn && (state == S_IDLE);
    strb.quietBreak = !rxEn || (state != S_IDLE) || (tick && !rxS);
    if (tick && cnt == LAST) begin
      if (state == S_DATA) begin
        strb.shiftEn = 1'b1;
        strb.bitVal  = rxS;
      end
      if (state == S_STOP) strb.frameOk = rxS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !rxEn) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (tick) begin
      case (state)
        S_IDLE: if (!rxS) begin
          state <= S_START;
          cnt   <= '0;
        end
        S_START: begin
          if (cnt == HALF) begin
            cnt    <= '0;
            bitIdx <= '0;
            state  <= rxS ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            bitIdx <= bitIdx + 1'b1;
            if (bitIdx == BIT_LAST) state <= S_STOP;
          end
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= S_IDLE;
        end
      endcase
    end
  end

  AST_RX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> state == S_IDLE) else $error("receiver not idle while off"); // R2

  AST_START_NOISE: assert property (@(posedge clk) disable iff (!rstN)
    (rxEn && tick && state == S_START && cnt == HALF && rxS) |=> state == S_IDLE)
    else $error("noisy start accepted"); // R8
endmodule

// File: rtl/mute_uart_rx_dp.sv
module mute_uart_rx_dp
  import mute_uart_rx_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int DATA_BITS  = 8,
  parameter int FRAME_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            strb,
  input  logic                 ctlWe,
  input  logic [7:0]           ctlWdata,
  input  logic                 ackRd,
  output logic                 rxEn,
  output logic [7:0]           ctlQ,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 dataReady,
  output logic                 overrun,
  output logic                 idleFlag,
  output logic                 rxIrq,
  output logic                 idleIrq
);
  localparam int IDLE_TICKS = FRAME_BITS * OVS;
  localparam int IDLE_W     = $clog2(IDLE_TICKS + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_TICKS - 1);

  logic                 rxIe, idleIe, muteQ;
  logic [DATA_BITS-1:0] shiftQ;
  logic                 everRx, armed, idleHit;
  logic [IDLE_W-1:0]    quietCnt;
  logic                 takeChar;

  assign takeChar = strb.frameOk && !muteQ;
  assign idleHit  = armed && strb.quietTick && !strb.quietBreak && (quietCnt == IDLE_LAST);

  // control word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxIe <= 1'b0; idleIe <= 1'b0; rxEn <= 1'b0; muteQ <= 1'b0;
    end else if (ctlWe) begin
      rxIe   <= ctlWdata[5];
      idleIe <= ctlWdata[4];
      rxEn   <= ctlWdata[2];
      muteQ  <= ctlWdata[1];
    end else if (idleHit) begin
      muteQ <= 1'b0;
    end
  end
  assign ctlQ = {2'b00, rxIe, idleIe, 1'b0, rxEn, muteQ, 1'b0};

  // shift and data registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      rxData <= '0;
    end else begin
      if (strb.shiftEn) shiftQ <= {strb.bitVal, shiftQ[DATA_BITS-1:1]};
      if (takeChar && !dataReady) rxData <= shiftQ;
    end
  end

  // flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReady <= 1'b0; overrun <= 1'b0; idleFlag <= 1'b0;
    end else begin
      if (takeChar)      dataReady <= 1'b1;
      else if (ackRd)    dataReady <= 1'b0;
      if (takeChar && dataReady) overrun <= 1'b1;
      else if (ackRd)            overrun <= 1'b0;
      if (idleHit)       idleFlag <= 1'b1;
      else if (ackRd)    idleFlag <= 1'b0;
    end
  end

  // idle-line arming and timing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      everRx   <= 1'b0;
      armed    <= 1'b0;
      quietCnt <= '0;
    end else begin
      if (takeChar) everRx <= 1'b1;
      if (!rxEn || idleHit)                    armed <= 1'b0;
      else if (takeChar || (strb.frameOk && everRx)) armed <= 1'b1;
      if (strb.quietBreak || !armed)           quietCnt <= '0;
      else if (strb.quietTick)                 quietCnt <= quietCnt + 1'b1;
    end
  end

  assign rxIrq   = rxIe && (dataReady || overrun);
  assign idleIrq = idleIe && idleFlag;

  AST_OVR_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(dataReady)) else $error("overrun without ready"); // R5

  AST_READY_ON_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameOk && !muteQ) |=> dataReady) else $error("frame lost"); // R3

  AST_MUTE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameOk && muteQ) |=> $stable(rxData)) else $error("muted frame stored"); // R10

  AST_IDLE_WAKES: assert property (@(posedge clk) disable iff (!rstN)
    (idleHit && !ctlWe) |=> (!muteQ && idleFlag)) else $error("idle did not wake"); // R11
endmodule

// File: rtl/mute_uart_rx.sv
module mute_uart_rx #(
  parameter int OVS        = 16,
  parameter int DATA_BITS  = 8,
  parameter int FRAME_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 rxIn,
  input  logic                 ctlWe,
  input  logic [7:0]           ctlWdata,
  input  logic                 ackRd,
  output logic [7:0]           ctlQ,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 dataReady,
  output logic                 overrun,
  output logic                 idleFlag,
  output logic                 rxIrq,
  output logic                 idleIrq
);
  import mute_uart_rx_pkg::*;

  rxStrobe_t strb;
  logic      rxEn;

  mute_uart_rx_ctrl #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .rxIn(rxIn), .rxEn(rxEn), .strb(strb)
  );

  mute_uart_rx_dp #(.OVS(OVS), .DATA_BITS(DATA_BITS), .FRAME_BITS(FRAME_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ctlWe(ctlWe), .ctlWdata(ctlWdata),
    .ackRd(ackRd), .rxEn(rxEn), .ctlQ(ctlQ), .rxData(rxData),
    .dataReady(dataReady), .overrun(overrun), .idleFlag(idleFlag),
    .rxIrq(rxIrq), .idleIrq(idleIrq)
  );
endmodule

// File: tb/mute_uart_rx_bench.sv
module mute_uart_rx_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       rxIn = 1'b1;
  logic       ctlWe = 1'b0;
  logic [7:0] ctlWdata = '0;
  logic       ackRd = 1'b0;
  logic [7:0] ctlQ, rxData;
  logic       dataReady, overrun, idleFlag, rxIrq, idleIrq;

  int errors = 0;
  int checks = 0;
  int tdiv = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 0);
  end

  mute_uart_rx u_mute_uart_rx (
    .clk(clk), .rstN(rstN), .tick(tick), .rxIn(rxIn), .ctlWe(ctlWe),
    .ctlWdata(ctlWdata), .ackRd(ackRd), .ctlQ(ctlQ), .rxData(rxData),
    .dataReady(dataReady), .overrun(overrun), .idleFlag(idleFlag),
    .rxIrq(rxIrq), .idleIrq(idleIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic writeCtl(input logic [7:0] v);
    @(negedge clk); ctlWe = 1'b1; ctlWdata = v;
    @(negedge clk); ctlWe = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); ackRd = 1'b1;
    @(negedge clk); ackRd = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] b, input bit goodStop);
    rxIn = 1'b0; waitTicks(16);
    for (int i = 0; i < 8; i++) begin
      rxIn = b[i]; waitTicks(16);
    end
    rxIn = goodStop;
    waitTicks(goodStop ? 16 : 11);
    rxIn = 1'b1;
    waitTicks(goodStop ? 0 : 12);
  endtask

  task automatic doReset();
    rstN = 1'b0; repeat (3) @(negedge clk); rstN = 1'b1; @(negedge clk);
  endtask

  task automatic tReset();
    chk("R1 ctl reset", ctlQ, 8'h00);
    chk("R1 flags reset", {dataReady, overrun, idleFlag, rxIrq, idleIrq}, 5'b0);
  endtask

  task automatic tDisabled();
    sendFrame(8'h5A, 1'b1); waitTicks(4);
    chk("R2 disabled ignores", {dataReady, rxData}, 9'h000);
  endtask

  task automatic tReceive();
    writeCtl(8'h24);
    chk("R1 readback", ctlQ, 8'h24);
    sendFrame(8'hA5, 1'b1); waitTicks(2);
    chk("R3 data", {dataReady, rxData}, 9'h1A5);
    chk("R4 rx irq", rxIrq, 1'b1);
  endtask

  task automatic tIdle();
    waitTicks(100);
    chk("R6 idle not early", idleFlag, 1'b0);
    waitTicks(75);
    chk("R6 idle set", idleFlag, 1'b1);
    chk("R6 idle irq gated off", idleIrq, 1'b0);
    writeCtl(8'h34);
    chk("R6 idle irq", idleIrq, 1'b1);
    ack();
    chk("R7 ack clears", {dataReady, idleFlag, rxIrq}, 3'b000);
    waitTicks(400);
    chk("R7 idle once", idleFlag, 1'b0);
  endtask

  task automatic tOverrun();
    sendFrame(8'h3C, 1'b1);
    sendFrame(8'hC3, 1'b1); waitTicks(2);
    chk("R5 overrun", {dataReady, overrun, rxData}, 10'h33C);
    chk("R4 irq on overrun", rxIrq, 1'b1);
    waitTicks(200); ack();
    chk("R7 ack clears overrun", {dataReady, overrun, idleFlag}, 3'b000);
  endtask

  task automatic tNoise();
    rxIn = 1'b0; waitTicks(3); rxIn = 1'b1; waitTicks(180);
    chk("R8 noise rejected", {dataReady, idleFlag}, 2'b00);
  endtask

  task automatic tBadStop();
    sendFrame(8'h81, 1'b0); waitTicks(180);
    chk("R9 bad stop dropped", {dataReady, idleFlag, rxData}, 10'h03C);
  endtask

  task automatic tMuteWake();
    writeCtl(8'h36);
    chk("R1 mute readback", ctlQ, 8'h36);
    sendFrame(8'h55, 1'b1); waitTicks(2);
    chk("R10 muted frame ignored", {dataReady, overrun, rxData}, 10'h03C);
    waitTicks(175);
    chk("R11 mute cleared", ctlQ, 8'h34);
    chk("R11 idle flag on wake", {idleFlag, idleIrq}, 2'b11);
    ack();
  endtask

  task automatic tMuteNoHistory();
    doReset();
    writeCtl(8'h06);
    sendFrame(8'h55, 1'b1); waitTicks(200);
    chk("R12 mute stays", ctlQ, 8'h06);
    chk("R12 no flags", {dataReady, idleFlag}, 2'b00);
    writeCtl(8'h04);
    sendFrame(8'h99, 1'b1); waitTicks(2);
    chk("R12 after sw unmute", {dataReady, rxData}, 9'h199);
  endtask

  initial begin
    doReset();
    tReset();
    tDisabled();
    tReceive();
    tIdle();
    tOverrun();
    tNoise();
    tBadStop();
    tMuteWake();
    tMuteNoHistory();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule